// File: doc/BRIEF.md
# Bridge Data-Phase Parity Error Reporter

This unit watches the data phases on one side of a two-port PCI-to-PCI bridge. A data phase completes when IRDY and TRDY are both asserted. The parity bit for that phase arrives one clock later. The unit then checks even parity over the data and byte-enable bits. It keeps a sticky detected-error status bit, and it drives the active-low PERR line with the usual drive-then-release sequence.

It covers two error sources:

- **Local errors.** The data arrived on this bus with bad parity. The unit sets the status bit, and pulls PERR when the response enable allows it.
- **Passed-back errors.** A flag reports that the opposite bus saw the error. The unit does not set the status bit, and the transaction completes normally. PERR still follows the response enable.

For a retried delayed write, the unit compares the retried data, byte enables and parity with the queued copy. It pulses a release strobe only on an exact match with no local parity error, so the stored write status can be returned. Otherwise the entry stays queued.

Top module: `bpe_unit`

## Requirements
- R1: A data phase completes in cycle T when `irdy_i` and `trdy_i` are both high. `par_i` in cycle T+1 is its parity. A local error exists when the XOR of `ad_i`, `cbe_i` (both captured in T) and `par_i` (in T+1) is 1. A local error makes `par_err_det_o` read 1 from cycle T+2.
- R2: When `perr_resp_en_i` is high in T+1 and the phase had a local error, `perr_o` is 0 in cycle T+2 only, for that phase.
- R3: In every cycle where `perr_o` is 0, `perr_oe_o` is 1. After each low cycle, `perr_oe_o` stays 1 and `perr_o` is 1 for one more cycle. After that, `perr_oe_o` returns to 0 unless another phase requests a low cycle. When idle, `perr_o` is 1 and `perr_oe_o` is 0.
- R4: When `perr_resp_en_i` is low in T+1, a local error still sets `par_err_det_o` but never pulls `perr_o` low.
- R5: A phase with `fwd_err_i` high in T and `perr_resp_en_i` high in T+1 gives `perr_o` = 0 in T+2. If parity was good, `par_err_det_o` is not set.
- R6: A passed-back error with `perr_resp_en_i` low in T+1 leaves `perr_o` high and `perr_oe_o` low.
- R7: For a phase with `dw_retry_i` high in T, `dw_release_o` is 1 in cycle T+2 for one cycle when all of the following hold:
  - `ad_i` and `cbe_i` in T equal `q_ad_i` and `q_cbe_i` in T+1;
  - `par_i` in T+1 equals `q_par_i`;
  - there was no local error.
- R8: Any mismatch in data, byte enables or parity, or a local error, keeps `dw_release_o` at 0 for that retry.
- R9: A passed-back error does not block the release of a matching retry.
- R10: `par_err_det_o` is sticky. It clears on the edge where `stat_wr_i` and `stat_wdata_i` are both 1. A write with `stat_wdata_i` = 0 changes nothing.
- R11: If a local error and a clearing write fall on the same edge, `par_err_det_o` stays 1.
- R12: During reset, `perr_o` = 1, `perr_oe_o` = 0, `par_err_det_o` = 0 and `dw_release_o` = 0.
- R13: A cycle without both `irdy_i` and `trdy_i` high is not a data phase. It affects neither PERR, the status bit nor the release strobe, whatever its parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data bus |
| cbe_i | input | 4 | Byte enables for the data phase |
| par_i | input | 1 | Even parity, valid one cycle after the data phase |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| perr_resp_en_i | input | 1 | Parity error response enable |
| fwd_err_i | input | 1 | Error passed back from the opposite bus for this phase |
| dw_retry_i | input | 1 | This phase is a retry of a queued delayed write |
| q_ad_i | input | 32 | Queued write data |
| q_cbe_i | input | 4 | Queued byte enables |
| q_par_i | input | 1 | Queued parity |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 1 | Write data for the status bit, 1 clears it |
| perr_o | output | 1 | PERR level, active low |
| perr_oe_o | output | 1 | PERR driver enable |
| par_err_det_o | output | 1 | Sticky parity-error-detected status |
| dw_release_o | output | 1 | Release of the queued write status |

## Verification
Two pairs of functions can fall in the same cycle.

- **Status set and software clear.** A local parity error is placed so that its check cycle carries a clearing status write. The status must stay set.
- **Retry release and passed-back error.** A matching retry of a delayed write carries a passed-back error. PERR must pulse and the release strobe must fire in the same cycle.

A bench model built from the requirements predicts every output in every cycle. It runs through directed cases and then through random phases in which retries, corrupted parity, passed-back flags and clearing writes overlap freely.

// File: rtl/bpe_pkg.sv
`timescale 1ns/1ps
package bpe_pkg;
  localparam int unsigned LANE_W = 8;

  typedef struct packed {
    logic valid;
    logic fwd;
    logic retry;
  } bpe_flags_t;
endpackage

// File: rtl/bpe_capture.sv
`timescale 1ns/1ps
module bpe_capture
  import bpe_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = DW / LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ad_i,
  input  logic [BW-1:0] cbe_i,
  input  logic          irdy_i,
  input  logic          trdy_i,
  input  logic          fwd_err_i,
  input  logic          dw_retry_i,
  output logic [DW-1:0] ph_ad_o,
  output logic [BW-1:0] ph_cbe_o,
  output bpe_flags_t    ph_flags_o
);
  logic xfer;
  assign xfer = irdy_i & trdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_ad_o    <= '0;
      ph_cbe_o   <= '0;
      ph_flags_o <= '0;
    end else begin
      ph_flags_o.valid <= xfer;
      ph_flags_o.fwd   <= xfer & fwd_err_i;
      ph_flags_o.retry <= xfer & dw_retry_i;
      if (xfer) begin
        ph_ad_o  <= ad_i;
        ph_cbe_o <= cbe_i;
      end
    end
  end

  // Flags can only be set on a real data phase
  p_flags_need_xfer_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_flags_o.fwd | ph_flags_o.retry) |-> ph_flags_o.valid);
endmodule

// File: rtl/bpe_check.sv
`timescale 1ns/1ps
module bpe_check
  import bpe_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = DW / LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ph_ad_i,
  input  logic [BW-1:0] ph_cbe_i,
  input  bpe_flags_t    ph_flags_i,
  input  logic          par_i,
  input  logic          perr_resp_en_i,
  input  logic [DW-1:0] q_ad_i,
  input  logic [BW-1:0] q_cbe_i,
  input  logic          q_par_i,
  output logic          loc_err_o,
  output logic          perr_req_o,
  output logic          release_o
);
  logic [BW-1:0] lane_par;
  logic          exact;

  for (genvar g = 0; g < BW; g++) begin : g_lane
    assign lane_par[g] = (^ph_ad_i[g*LANE_W +: LANE_W]) ^ ph_cbe_i[g];
  end

  assign loc_err_o = ph_flags_i.valid & ((^lane_par) ^ par_i);
  assign exact     = (ph_ad_i == q_ad_i) & (ph_cbe_i == q_cbe_i) & (par_i == q_par_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_req_o <= 1'b0;
      release_o  <= 1'b0;
    end else begin
      perr_req_o <= ph_flags_i.valid & perr_resp_en_i & (loc_err_o | ph_flags_i.fwd);
      release_o  <= ph_flags_i.retry & exact & ~loc_err_o;
    end
  end

  // A disabled response never requests a PERR pulse
  p_req_needs_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_resp_en_i |=> !perr_req_o);
endmodule

// File: rtl/bpe_perr_drv.sv
`timescale 1ns/1ps
module bpe_perr_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic perr_o,
  output logic perr_oe_o
);
  logic tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= 1'b0;
    else         tail_q <= req_i;
  end

  assign perr_o    = ~req_i;
  assign perr_oe_o = req_i | tail_q;

  p_low_is_driven_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_o |-> perr_oe_o);

  p_drive_after_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_o |=> perr_oe_o);

  p_high_before_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!perr_oe_o && $past(perr_oe_o)) |-> $past(perr_o));
endmodule

// File: rtl/bpe_status.sv
`timescale 1ns/1ps
module bpe_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic det_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               det_o <= 1'b0;
    else if (set_i)            det_o <= 1'b1;  // set beats clear
    else if (wr_i && wdata_i)  det_o <= 1'b0;
  end

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> det_o);

  p_clear_only_by_w1_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(det_o) |-> $past(wr_i && wdata_i));
endmodule

// File: rtl/bpe_unit.sv
`timescale 1ns/1ps
module bpe_unit
  import bpe_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned BW = DW / LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ad_i,
  input  logic [BW-1:0] cbe_i,
  input  logic          par_i,
  input  logic          irdy_i,
  input  logic          trdy_i,
  input  logic          perr_resp_en_i,
  input  logic          fwd_err_i,
  input  logic          dw_retry_i,
  input  logic [DW-1:0] q_ad_i,
  input  logic [BW-1:0] q_cbe_i,
  input  logic          q_par_i,
  input  logic          stat_wr_i,
  input  logic          stat_wdata_i,
  output logic          perr_o,
  output logic          perr_oe_o,
  output logic          par_err_det_o,
  output logic          dw_release_o
);
  logic [DW-1:0] ph_ad;
  logic [BW-1:0] ph_cbe;
  bpe_flags_t    ph_flags;
  logic          loc_err;
  logic          perr_req;

  bpe_capture #(.DW(DW), .BW(BW)) i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ad_i       (ad_i),
    .cbe_i      (cbe_i),
    .irdy_i     (irdy_i),
    .trdy_i     (trdy_i),
    .fwd_err_i  (fwd_err_i),
    .dw_retry_i (dw_retry_i),
    .ph_ad_o    (ph_ad),
    .ph_cbe_o   (ph_cbe),
    .ph_flags_o (ph_flags)
  );

  bpe_check #(.DW(DW), .BW(BW)) i_check (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ph_ad_i        (ph_ad),
    .ph_cbe_i       (ph_cbe),
    .ph_flags_i     (ph_flags),
    .par_i          (par_i),
    .perr_resp_en_i (perr_resp_en_i),
    .q_ad_i         (q_ad_i),
    .q_cbe_i        (q_cbe_i),
    .q_par_i        (q_par_i),
    .loc_err_o      (loc_err),
    .perr_req_o     (perr_req),
    .release_o      (dw_release_o)
  );

  bpe_perr_drv i_perr_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (perr_req),
    .perr_o    (perr_o),
    .perr_oe_o (perr_oe_o)
  );

  bpe_status i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (loc_err),
    .wr_i    (stat_wr_i),
    .wdata_i (stat_wdata_i),
    .det_o   (par_err_det_o)
  );

  // A retry with a fresh local error must not release
  p_no_release_on_local_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_release_o |-> !$rose(par_err_det_o));
endmodule

// File: tb/test_bpe_unit.sv
`timescale 1ns/1ps
module test_bpe_unit;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        par_i = 1'b0;
  logic        irdy_i = 1'b0;
  logic        trdy_i = 1'b0;
  logic        perr_resp_en_i = 1'b0;
  logic        fwd_err_i = 1'b0;
  logic        dw_retry_i = 1'b0;
  logic [31:0] q_ad_i = 32'hCAFE_0123;
  logic [3:0]  q_cbe_i = 4'h5;
  logic        q_par_i = 1'b0;
  logic        stat_wr_i = 1'b0;
  logic        stat_wdata_i = 1'b0;
  logic        perr_o, perr_oe_o, par_err_det_o, dw_release_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench-side model state
  bit        s1_v, s1_fwd, s1_rty, s1_bad;
  bit [31:0] s1_ad;
  bit [3:0]  s1_be;
  bit        m_req;
  bit        e_perr = 1'b1, e_oe = 1'b0, e_det = 1'b0, e_rel = 1'b0;

  bpe_unit i_bpe_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
    .irdy_i(irdy_i), .trdy_i(trdy_i), .perr_resp_en_i(perr_resp_en_i),
    .fwd_err_i(fwd_err_i), .dw_retry_i(dw_retry_i), .q_ad_i(q_ad_i),
    .q_cbe_i(q_cbe_i), .q_par_i(q_par_i), .stat_wr_i(stat_wr_i),
    .stat_wdata_i(stat_wdata_i), .perr_o(perr_o), .perr_oe_o(perr_oe_o),
    .par_err_det_o(par_err_det_o), .dw_release_o(dw_release_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic bit good_par(input bit [31:0] a, input bit [3:0] b);
    return ^{a, b};
  endfunction

  task automatic chk(input logic act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(perr_o,        e_perr, "R2 R4 R5 R6 R13 perr_o");
    chk(perr_oe_o,     e_oe,   "R3 perr_oe_o");
    chk(par_err_det_o, e_det,  "R1 R10 R11 par_err_det_o");
    chk(dw_release_o,  e_rel,  "R7 R8 R9 dw_release_o");
  endtask

  // One clock: check, drive, predict. Called at a negedge.
  task automatic step(input bit irdy, input bit trdy, input bit [31:0] ad,
                      input bit [3:0] be, input bit bad, input bit fwd,
                      input bit rty, input bit ren, input bit wr, input bit wd);
    bit par_now, loc, nreq;
    check_all();
    par_now = good_par(s1_ad, s1_be) ^ s1_bad;
    irdy_i = irdy; trdy_i = trdy; ad_i = ad; cbe_i = be;
    fwd_err_i = fwd; dw_retry_i = rty; perr_resp_en_i = ren;
    stat_wr_i = wr; stat_wdata_i = wd; par_i = par_now;
    loc   = s1_v && (^{s1_ad, s1_be, par_now});
    nreq  = s1_v && ren && (loc || s1_fwd);
    e_oe  = nreq || m_req;
    m_req = nreq;
    e_perr = !nreq;
    e_rel = s1_v && s1_rty && (s1_ad == q_ad_i) && (s1_be == q_cbe_i) &&
            (par_now == q_par_i) && !loc;
    if (loc) e_det = 1'b1;
    else if (wr && wd) e_det = 1'b0;
    if (irdy && trdy) begin
      s1_ad = ad; s1_be = be;
    end
    s1_v = irdy && trdy; s1_fwd = fwd; s1_rty = rty; s1_bad = bad;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n, input bit ren);
    for (int i = 0; i < n; i++) step(0, 0, 32'h0, 4'h0, 0, 0, 0, ren, 0, 0);
  endtask

  task automatic xfer(input bit [31:0] ad, input bit [3:0] be, input bit bad,
                      input bit fwd, input bit rty, input bit ren);
    step(1, 1, ad, be, bad, fwd, rty, ren, 0, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    q_par_i = good_par(q_ad_i, q_cbe_i);
    @(negedge clk_i);
    // R12 reset state
    chk(perr_o, 1'b1, "R12 perr_o in reset");
    chk(perr_oe_o, 1'b0, "R12 perr_oe_o in reset");
    chk(par_err_det_o, 1'b0, "R12 status in reset");
    chk(dw_release_o, 1'b0, "R12 release in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2, 1);

    xfer(32'h1234_5678, 4'hF, 0, 0, 0, 1);  // clean phase
    idle(3, 1);
    xfer(32'hA5A5_0F0F, 4'h3, 1, 0, 0, 1);  // R1 R2 R3 local error, enabled
    idle(4, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);    // R10 write 0 no effect
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);    // R10 write 1 clears
    idle(2, 1);
    xfer(32'h0000_00FF, 4'h1, 1, 0, 0, 0);  // R4 error, disabled
    idle(4, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    xfer(32'h1111_2222, 4'hC, 0, 1, 0, 1);  // R5 passed-back, enabled
    idle(4, 1);
    xfer(32'h1111_2222, 4'hC, 0, 1, 0, 0);  // R6 passed-back, disabled
    idle(4, 0);
    step(1, 0, 32'hDEAD_BEEF, 4'h7, 1, 1, 1, 1, 0, 0); // R13 IRDY only
    step(0, 1, 32'hDEAD_BEEF, 4'h7, 1, 1, 1, 1, 0, 0); // R13 TRDY only
    idle(4, 1);
    xfer(q_ad_i, q_cbe_i, 0, 0, 1, 1);      // R7 exact match
    idle(3, 1);
    xfer(q_ad_i ^ 32'h10, q_cbe_i, 0, 0, 1, 1); // R8 data mismatch
    idle(3, 1);
    xfer(q_ad_i, q_cbe_i ^ 4'h2, 0, 0, 1, 1);   // R8 byte-enable mismatch
    idle(3, 1);
    xfer(q_ad_i, q_cbe_i, 1, 0, 1, 1);      // R8 parity error on retry
    idle(3, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    xfer(q_ad_i, q_cbe_i, 0, 1, 1, 1);      // R9 passed-back with match
    idle(3, 1);
    xfer(32'h7777_0000, 4'h9, 1, 0, 0, 1);  // R11 set and clear collide
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    idle(3, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    xfer(32'h0101_0101, 4'hF, 1, 0, 0, 1);  // back-to-back errors
    xfer(32'h0202_0202, 4'hF, 1, 0, 0, 1);
    xfer(32'h0303_0303, 4'hF, 0, 0, 0, 1);
    xfer(32'h0404_0404, 4'hF, 1, 0, 0, 1);
    idle(4, 1);

    for (int i = 0; i < 3000; i++) begin
      bit rty = ($urandom % 3) == 0;
      bit [31:0] a = (rty && ($urandom % 2)) ? q_ad_i : $urandom;
      bit [3:0]  b = (rty && ($urandom % 4) != 0) ? q_cbe_i : 4'($urandom);
      step(($urandom % 4) != 0, ($urandom % 4) != 0, a, b,
           ($urandom % 5) == 0, ($urandom % 6) == 0, rty,
           ($urandom % 4) != 0, ($urandom % 8) == 0, $urandom % 2);
    end
    idle(4, 1);
    check_all();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule